// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block derives a set of related clock outputs from one fast system clock: a CPU group, a free-running PCI reference (PCI_F), a stoppable PCI group, a reference clock and a 48 MHz group. Every output comes from a flip-flop inside a divider, so no output is ever a gated copy of a raw clock. Each divider has a free-running phase. An output may go high only where its phase begins a high half, and it always goes low where that half ends. Pulses are therefore complete whenever a clock is stopped or restarted.

Three active-low controls govern the outputs. The CPU stop input and the PCI stop input may arrive at any time. They are synchronised, then sampled on PCI_F rising events, and they act one PCI_F rising edge later. The stop input for the CPU affects only CPU output 0. The PCI stop input affects only the stoppable PCI group. The power-down input must be seen low on two consecutive CPU rising events before the CPU and PCI outputs stop at their next falling edge. The reference and 48 MHz outputs are forced low as soon as the synchronised power-down level reaches them. A per-output enable bit holds an output low. Because only rising edges are gated, an enable change takes effect only while that output is low. A status output reports when power-down is in force and every output has reached the low level.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, every clock output and `pd_done` are 0.
- R2: Every high pulse on an output lasts exactly its half period in `clk` cycles (defaults: CPU 2, PCI_F and PCI 8, reference 7, 48 MHz 5). This holds across stops, restarts and enable changes, except for the reference and 48 MHz outputs at a power-down cut.
- R3: With `cpu_stp_n` low, CPU output 0 stops and stays low within two PCI_F periods. CPU outputs 1 and 2 and the PCI outputs keep toggling at full rate. After `cpu_stp_n` returns high, CPU output 0 toggles again at full rate.
- R4: With `pci_stp_n` low, every PCI group output stays low. PCI_F keeps toggling.
- R5: Suppose a stop input changes in the cycle right after a PCI_F rising edge. The change is captured at the next PCI_F rising edge and governs the outputs from the PCI_F rising edge after that. When stopping, exactly one more PCI rising edge appears. When releasing, the first PCI rise coincides with the second PCI_F rise after the change.
- R6: Suppose `pd_n` is low on two consecutive CPU rising events. The CPU, PCI_F and PCI outputs then stop low at their next falling edge. `pd_done` becomes 1 within 60 cycles, and all outputs stay low while `pd_n` stays low.
- R7: Three `clk` cycles after `pd_n` goes low, the reference and 48 MHz outputs are 0, whatever the CPU sampling has done.
- R8: After `pd_n` returns high, `pd_done` is 0 within four cycles. All outputs then resume at full rate with complete pulses.
- R9: An output whose enable bit is 0 (1 means enabled) makes no rising edge. Clearing the bit while the output is high lets that high pulse finish at full width.
- R10: A `pd_n` low level lasting fewer than four `clk` cycles does not stop the CPU, PCI_F or PCI outputs, and does not set `pd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that all dividers count |
| rst | input | 1 | Synchronous reset, active high |
| cpu_stp_n | input | 1 | Asynchronous stop request for CPU output 0, active low |
| pci_stp_n | input | 1 | Asynchronous stop request for the PCI group, active low |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| en_cpu | input | NCPU | Enable per CPU output, 1 = enabled |
| en_pcif | input | 1 | Enable for PCI_F, 1 = enabled |
| en_pci | input | NPCI | Enable per PCI output, 1 = enabled |
| en_ref | input | 1 | Enable for the reference output |
| en_usb | input | NUSB | Enable per 48 MHz output |
| cpu_clk | output | NCPU | CPU group clocks |
| pcif_clk | output | 1 | Free-running PCI reference clock |
| pci_clk | output | NPCI | Stoppable PCI clocks, in phase with PCI_F |
| ref_clk | output | 1 | Reference clock |
| usb_clk | output | NUSB | 48 MHz group clocks |
| pd_done | output | 1 | Power-down in force and all outputs low |

## Verification
A wrong divider phase or gating state shows up at the ports as a high pulse of the wrong width on the very next falling edge. It can also appear as a rising edge counted where a stopped output should stay flat. A capture register taken at the wrong PCI_F event moves the last or first PCI pulse by one PCI_F period, 16 cycles, and the scoreboard checks at that exact cycle. A power-down sequencer in the wrong state either leaves outputs running, seen within one PCI_F period of the expected stop, or sets `pd_done` while something is still toggling.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_SEEN1 = 2'd1,
    PD_DOWN  = 2'd2
  } pd_state_t;
endpackage

// File: rtl/clkstop_sync2.sv
`timescale 1ns/1ps
module clkstop_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/clkstop_div.sv
`timescale 1ns/1ps
module clkstop_div #(
  parameter int HALF = 2,
  parameter int N    = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] run,
  input  logic         force_low,
  output logic [N-1:0] out,
  output logic         rise_evt
);
  localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          ph;
  logic          tick;

  assign tick     = (cnt == LAST);
  assign rise_evt = tick & ~ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick) ph <= ~ph;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)            out[i] <= 1'b0;
      else if (force_low) out[i] <= 1'b0;
      else if (tick)      out[i] <= ~ph & run[i];
    end

    // R2: a rise only opens a fresh high half
    assert_rise_phase_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(out[i]) |-> (cnt == '0 && ph));
    // R2: a fall only closes a high half, unless forced
    assert_fall_phase_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(out[i]) |-> ((cnt == '0 && !ph) || $past(force_low)));
  end
endmodule

// File: rtl/clkstop_pdctl.sv
`timescale 1ns/1ps
module clkstop_pdctl
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_n_s,
  input  logic sample,
  output logic pd_active
);
  pd_state_t st;

  always_ff @(posedge clk) begin
    if (rst || pd_n_s) begin
      st <= PD_RUN;
    end else if (sample) begin
      case (st)
        PD_RUN:   st <= PD_SEEN1;
        PD_SEEN1: st <= PD_DOWN;
        default:  st <= PD_DOWN;
      endcase
    end
  end

  assign pd_active = (st == PD_DOWN);

  assert_two_samples_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> ($past(sample) && !$past(pd_n_s)));
  assert_exit_clear_R8: assert property (@(posedge clk) disable iff (rst)
    pd_n_s |=> !pd_active);
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
  parameter int NCPU     = 3,
  parameter int NPCI     = 6,
  parameter int NUSB     = 2,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 8,
  parameter int REF_HALF = 7,
  parameter int USB_HALF = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_stp_n,
  input  logic            pci_stp_n,
  input  logic            pd_n,
  input  logic [NCPU-1:0] en_cpu,
  input  logic            en_pcif,
  input  logic [NPCI-1:0] en_pci,
  input  logic            en_ref,
  input  logic [NUSB-1:0] en_usb,
  output logic [NCPU-1:0] cpu_clk,
  output logic            pcif_clk,
  output logic [NPCI-1:0] pci_clk,
  output logic            ref_clk,
  output logic [NUSB-1:0] usb_clk,
  output logic            pd_done
);
  localparam int NPG = NPCI + 1;

  logic [2:0]      ctl_s;
  logic            cpu_go, pci_go;
  logic            pd_active;
  logic            cpu_rise, pcif_rise, ref_rise, usb_rise;
  logic [NCPU-1:0] cpu_run;
  logic [NPG-1:0]  pg_run, pg_out;
  logic            slow_force;

  clkstop_sync2 #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst(rst), .din({pd_n, pci_stp_n, cpu_stp_n}), .dout(ctl_s));

  // stop requests are taken only on PCI_F rising events
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_go <= 1'b1;
      pci_go <= 1'b1;
    end else if (pcif_rise) begin
      cpu_go <= ctl_s[0];
      pci_go <= ctl_s[1];
    end
  end

  clkstop_pdctl u_pd (
    .clk(clk), .rst(rst), .pd_n_s(ctl_s[2]), .sample(cpu_rise), .pd_active(pd_active));

  always_comb begin
    cpu_run    = en_cpu & {NCPU{~pd_active}};
    cpu_run[0] = cpu_run[0] & cpu_go;
    pg_run     = {en_pci & {NPCI{pci_go & ~pd_active}}, en_pcif & ~pd_active};
  end

  assign slow_force = ~ctl_s[2];

  clkstop_div #(.HALF(CPU_HALF), .N(NCPU)) u_cpu (
    .clk(clk), .rst(rst), .run(cpu_run), .force_low(1'b0),
    .out(cpu_clk), .rise_evt(cpu_rise));

  clkstop_div #(.HALF(PCI_HALF), .N(NPG)) u_pci (
    .clk(clk), .rst(rst), .run(pg_run), .force_low(1'b0),
    .out(pg_out), .rise_evt(pcif_rise));

  clkstop_div #(.HALF(REF_HALF), .N(1)) u_ref (
    .clk(clk), .rst(rst), .run(en_ref), .force_low(slow_force),
    .out(ref_clk), .rise_evt(ref_rise));

  clkstop_div #(.HALF(USB_HALF), .N(NUSB)) u_usb (
    .clk(clk), .rst(rst), .run(en_usb), .force_low(slow_force),
    .out(usb_clk), .rise_evt(usb_rise));

  assign pcif_clk = pg_out[0];
  assign pci_clk  = pg_out[NPG-1:1];

  always_ff @(posedge clk) begin
    if (rst) pd_done <= 1'b0;
    else     pd_done <= pd_active & ~ctl_s[2] &
                        ~|{cpu_clk, pcif_clk, pci_clk, ref_clk, usb_clk};
  end

  assert_cpu0_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_go) |-> !$rose(cpu_clk[0]));
  assert_pci_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(pci_go) |-> ((pci_clk & ~$past(pci_clk)) == '0));
  assert_pcif_free_R4: assert property (@(posedge clk) disable iff (rst)
    $past(pcif_rise && en_pcif && !pd_active) |-> pcif_clk);
  assert_capture_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_go != $past(cpu_go) || pci_go != $past(pci_go)) |-> $past(pcif_rise));
  assert_done_low_R6: assert property (@(posedge clk) disable iff (rst)
    pd_done |-> ({cpu_clk, pcif_clk, pci_clk, ref_clk, usb_clk} == '0));
  assert_slow_forced_R7: assert property (@(posedge clk) disable iff (rst)
    !ctl_s[2] |=> (!ref_clk && usb_clk == '0));
  assert_slow_rise_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(ref_clk) |-> $past(ref_rise)) and ($rose(usb_clk[0]) |-> $past(usb_rise)));
  assert_en_gate_R9: assert property (@(posedge clk) disable iff (rst)
    ((pci_clk & ~$past(pci_clk) & ~$past(en_pci)) == '0));
endmodule

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
  localparam int NCPU = 3, NPCI = 6, NUSB = 2;
  localparam int CPU_HALF = 2, PCI_HALF = 8, REF_HALF = 7, USB_HALF = 5;
  localparam int EQ = 0, GE = 1;
  localparam int CNT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_stp_n = 1'b1, pci_stp_n = 1'b1, pd_n = 1'b1;
  logic [NCPU-1:0] en_cpu = '1;
  logic            en_pcif = 1'b1;
  logic [NPCI-1:0] en_pci = '1;
  logic            en_ref = 1'b1;
  logic [NUSB-1:0] en_usb = '1;
  logic [NCPU-1:0] cpu_clk;
  logic            pcif_clk;
  logic [NPCI-1:0] pci_clk;
  logic            ref_clk;
  logic [NUSB-1:0] usb_clk;
  logic            pd_done;

  always #2.5 clk = ~clk;

  clkstop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .NUSB(NUSB), .CPU_HALF(CPU_HALF),
    .PCI_HALF(PCI_HALF), .REF_HALF(REF_HALF), .USB_HALF(USB_HALF)) dut_i (
    .clk(clk), .rst(rst), .cpu_stp_n(cpu_stp_n), .pci_stp_n(pci_stp_n), .pd_n(pd_n),
    .en_cpu(en_cpu), .en_pcif(en_pcif), .en_pci(en_pci), .en_ref(en_ref), .en_usb(en_usb),
    .cpu_clk(cpu_clk), .pcif_clk(pcif_clk), .pci_clk(pci_clk), .ref_clk(ref_clk),
    .usb_clk(usb_clk), .pd_done(pd_done));

  int nchk = 0, nfail = 0, cyc = 0;
  bit ign = 1'b0;
  int rises[8];
  int hw[8];
  logic [7:0] prev = '0;
  logic [7:0] lv;

  typedef struct {int at; int sel; int mode; int val; string req;} item_t;
  item_t sbq[$];

  assign lv = {usb_clk[0], ref_clk, pci_clk[NPCI-1], pci_clk[0], pcif_clk,
               cpu_clk[2], cpu_clk[1], cpu_clk[0]};

  function automatic int half_of(int k);
    if (k < 3) return CPU_HALF;
    if (k < 6) return PCI_HALF;
    if (k == 6) return REF_HALF;
    return USB_HALF;
  endfunction

  function automatic int probe(int sel);
    if (sel < 8) return int'(lv[sel]);
    if (sel == 8) return int'(pd_done);
    return rises[sel-CNT];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pulse widths, rise counts, scoreboard compare
  always @(negedge clk) begin
    for (int k = 0; k < 8; k++) begin
      if (lv[k] && !prev[k]) begin
        rises[k]++;
        hw[k] = 1;
      end else if (lv[k]) begin
        hw[k]++;
      end else if (prev[k] && !rst && !(ign && k >= 6)) begin
        chk(hw[k] == half_of(k), $sformatf("R2 width sig%0d", k), hw[k], half_of(k));
      end
    end
    prev = lv;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at <= cyc) begin
        int a;
        a = probe(sbq[i].sel);
        chk((sbq[i].mode == EQ) ? (a == sbq[i].val) : (a >= sbq[i].val),
            sbq[i].req, a, sbq[i].val);
        sbq.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic push(input int dc, input int sel, input int mode, input int val, input string req);
    sbq.push_back('{cyc + dc, sel, mode, val, req});
  endtask

  task automatic wait_pcif_rise();
    bit p;
    bit got = 1'b0;
    while (!got) begin
      p = pcif_clk;
      step();
      got = pcif_clk && !p;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int snap[8];
    for (int k = 0; k < 8; k++) begin
      rises[k] = 0;
      hw[k] = 0;
    end
    // R1: reset state
    for (int k = 0; k < 8; k++) push(3, k, EQ, 0, "R1 output low in reset");
    push(3, 8, EQ, 0, "R1 pd_done low in reset");
    repeat (6) step();
    rst = 1'b0;
    repeat (40) step();

    // R4/R5: PCI stop, one more PCI pulse then flat
    wait_pcif_rise();
    pci_stp_n = 1'b0;
    push(17, CNT+4, EQ, rises[4] + 1, "R5 last PCI pulse");
    push(30, 4, EQ, 0, "R4 PCI low");
    push(80, CNT+4, EQ, rises[4] + 1, "R4 PCI held");
    push(80, CNT+5, EQ, rises[5] + 1, "R4 PCI5 held");
    push(80, CNT+3, EQ, rises[3] + 5, "R4 PCI_F runs");
    repeat (84) step();

    // R5: release, first PCI rise on second PCI_F rise
    wait_pcif_rise();
    pci_stp_n = 1'b1;
    push(31, 4, EQ, 0, "R5 still low before restart");
    push(32, 4, EQ, 1, "R5 restart level");
    push(32, CNT+4, EQ, rises[4] + 1, "R5 restart count");
    push(32, CNT+3, EQ, rises[3] + 2, "R5 PCI_F edges");
    repeat (40) step();

    // R3: CPU0 only
    wait_pcif_rise();
    cpu_stp_n = 1'b0;
    repeat (32) step();
    push(2, 0, EQ, 0, "R3 CPU0 low");
    push(64, CNT+0, EQ, rises[0], "R3 CPU0 held");
    push(64, CNT+1, EQ, rises[1] + 16, "R3 CPU1 runs");
    push(64, CNT+2, EQ, rises[2] + 16, "R3 CPU2 runs");
    push(64, CNT+4, EQ, rises[4] + 4, "R3 PCI runs");
    repeat (66) step();
    cpu_stp_n = 1'b1;
    repeat (40) step();
    push(32, CNT+0, EQ, rises[0] + 8, "R3 CPU0 restart");
    repeat (34) step();

    // R9: disable PCI5 while high
    wait_pcif_rise();
    en_pci[NPCI-1] = 1'b0;
    push(7, 5, EQ, 1, "R9 pulse completes");
    push(8, 5, EQ, 0, "R9 falls on time");
    push(72, CNT+5, EQ, rises[5], "R9 disabled held");
    push(72, CNT+4, EQ, rises[4] + 4, "R9 others run");
    repeat (74) step();
    en_pci[NPCI-1] = 1'b1;
    repeat (40) step();

    // R10: short power-down glitch
    ign = 1'b1;
    wait_pcif_rise();
    pd_n = 1'b0;
    push(64, CNT+1, EQ, rises[1] + 16, "R10 CPU1 unaffected");
    push(64, CNT+3, EQ, rises[3] + 4, "R10 PCI_F unaffected");
    push(5, 8, EQ, 0, "R10 no pd_done");
    repeat (3) step();
    pd_n = 1'b1;
    repeat (70) step();
    ign = 1'b0;

    // R6/R7/R8: full power-down and exit
    ign = 1'b1;
    wait_pcif_rise();
    pd_n = 1'b0;
    push(3, 6, EQ, 0, "R7 REF forced low");
    push(3, 7, EQ, 0, "R7 48M forced low");
    repeat (60) step();
    for (int k = 0; k < 8; k++) push(1, k, EQ, 0, "R6 output stopped low");
    push(1, 8, EQ, 1, "R6 pd_done set");
    for (int k = 0; k < 8; k++) push(60, CNT+k, EQ, rises[k], "R6 held in power-down");
    repeat (62) step();
    pd_n = 1'b1;
    push(4, 8, EQ, 0, "R8 pd_done cleared");
    repeat (30) step();
    for (int k = 0; k < 8; k++) snap[k] = rises[k];
    push(64, CNT+1, EQ, snap[1] + 16, "R8 CPU1 resumed");
    push(64, CNT+0, EQ, snap[0] + 16, "R8 CPU0 resumed");
    push(64, CNT+3, EQ, snap[3] + 4, "R8 PCI_F resumed");
    push(64, CNT+4, EQ, snap[4] + 4, "R8 PCI resumed");
    push(64, CNT+6, GE, snap[6] + 4, "R8 REF resumed");
    push(64, CNT+7, GE, snap[7] + 6, "R8 48M resumed");
    repeat (66) step();
    ign = 1'b0;
    repeat (20) step();

    chk(sbq.size() == 0, "R2 scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule